// File: doc/BRIEF.md
# Half-Band Lowpass Filter with Folded Symmetric Taps

This block is a single-rate FIR lowpass whose cutoff lies at one quarter of the sample rate. It takes unsigned 12-bit converter samples, each qualified by a one-cycle strobe in a faster system clock domain, and returns one filtered sample for each strobe. Because the response is a half-band one, every tap at an even distance from the centre is zero. The only exception is the centre tap, which is exactly one half and is formed by a shift.

The coefficients are mirror-symmetric, so each pair of samples at the same odd distance from the centre is added before weighting. Each pair weight is a fixed constant built from shifted copies and an adder chain, and no multiplier is used. Inputs are converted to two's complement on entry by flipping the top bit. The full-precision sum is rounded, clipped to the 12-bit range and converted back to unsigned on exit. All stages advance only on a strobe, so the latency is a fixed number of strobes whatever the strobe spacing.

Top module: `hb_lowpass`

## Requirements
- R1: A synchronous reset clears the delay line, the pipeline and the valid flag, and sets the output to midscale code 2048. Reset takes priority over a strobe that arrives in the same cycle, and a sample offered with that strobe is not stored.
- R2: State changes only on a clock edge where `sample_en` is high. Between strobes, `out_data` holds its value, `out_valid` stays low, and `sample_in` has no effect.
- R3: The output produced from the window whose newest sample arrived on strobe k is loaded on strobe k+3. `out_valid` is a one-cycle pulse that follows each strobe, starting with the fourth strobe after reset.
- R4: The output equals the sum of w(d)·x over the 11 most recent signed samples, divided by 1024, where d is the distance of each sample from the centre sample (the sixth newest). The weights are w(0)=512, w(±1)=300, w(±3)=−56 and w(±5)=12, and w is zero at every other even distance.
- R5: The weights sum to 1024, so a constant input settles to exactly the same output code.
- R6: Rounding is half up: the result is floor((sum + 512) / 1024). A signed +0.5 rounds to +1, and −0.5 rounds to 0.
- R7: A rounded result above +2047 is clipped to code 4095, and one below −2048 is clipped to code 0, so step overshoot cannot wrap.
- R8: Samples are offset binary. Code 2048 is zero, and the signed value is the code minus 2048 on both the input and the output.
- R9: A quarter-rate input of codes 2048+A, 2048, 2048−A, 2048 settles to an output of amplitude A/2, which is half gain at fs/4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_en | input | 1 | Strobe that qualifies sample_in for one cycle |
| sample_in | input | 12 | Unsigned input sample |
| out_valid | output | 1 | One-cycle pulse after each strobe once the pipeline is full |
| out_data | output | 12 | Unsigned filtered sample |

## Verification
Two events can land in the same cycle. The first is reset together with a strobe carrying a full-scale sample. The bench raises both at once, checks that the output returns to midscale with valid low, and then confirms that the later outputs match a model whose history was cleared, which shows the offered sample was dropped. The second is clipping together with rounding: a full-range step makes the overshoot cross the rail, and each output around the edge is compared with a model that rounds and clips independently.

// File: rtl/hb_lowpass_pkg.sv
package hb_lowpass_pkg;

   // Fixed-point scale of all weights: 2^10.
   localparam int COEF_FRAC = 10;
   localparam int MAX_PAIRS = 3;

   // Weight of odd-distance pair j (distance 2j+1) for a filter with `pairs` pairs.
   function automatic int side_coef(input int pairs, input int j);
      int c;
      c = 0;
      case (pairs)
         1: c = 256;
         2: c = (j == 0) ? 288 : -32;
         3: begin
            case (j)
               0: c = 300;
               1: c = -56;
               default: c = 12;
            endcase
         end
         default: c = 0;
      endcase
      return c;
   endfunction

   // Total of all weights, centre included; must equal 2^COEF_FRAC.
   function automatic int weight_total(input int pairs);
      int s;
      s = 1 << (COEF_FRAC - 1);
      for (int j = 0; j < pairs; j++) s += 2 * side_coef(pairs, j);
      return s;
   endfunction

endpackage

// File: rtl/hb_tap_line.sv
module hb_tap_line #(
   parameter int W     = 12,
   parameter int TAPS  = 11,
   parameter int PAIRS = 3
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        en,
   input  logic signed [W-1:0]         din,
   output logic [PAIRS-1:0][W-1:0]     near_tap,
   output logic [PAIRS-1:0][W-1:0]     far_tap,
   output logic signed [W-1:0]         centre_tap
);
   localparam int MID = (TAPS - 1) / 2;

   logic signed [W-1:0] line [TAPS];

   always_ff @(posedge clk) begin
      if (rst)     line[0] <= '0;
      else if (en) line[0] <= din;
   end

   for (genvar i = 1; i < TAPS; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst)     line[i] <= '0;
         else if (en) line[i] <= line[i-1];
      end
   end

   for (genvar j = 0; j < PAIRS; j++) begin : g_pick
      assign near_tap[j] = line[MID - (2*j + 1)];
      assign far_tap[j]  = line[MID + (2*j + 1)];
   end
   assign centre_tap = line[MID];

   AST_LINE_SHIFT: assert property (@(posedge clk) disable iff (rst)
      en |=> (line[1] == $past(line[0]))) else $error("line shift"); // R2
   AST_LINE_CLEAR: assert property (@(posedge clk)
      rst |=> (line[TAPS-1] == '0 && line[0] == '0)) else $error("line clear"); // R1

endmodule

// File: rtl/hb_pair_mult.sv
module hb_pair_mult #(
   parameter int W      = 12,
   parameter int COEF   = 300,
   parameter int PROD_W = 23
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     en,
   input  logic [W-1:0]             a,
   input  logic [W-1:0]             b,
   output logic signed [PROD_W-1:0] prod
);
   localparam int PAIR_W = W + 1;
   localparam int MAG    = (COEF < 0) ? -COEF : COEF;
   localparam int NB     = $clog2(MAG + 1);

   if (COEF == 0) begin : g_bad_coef
      $error("hb_pair_mult: zero weight has no pair");
   end
   if (PROD_W < PAIR_W + NB) begin : g_bad_width
      $error("hb_pair_mult: product width too small");
   end

   logic signed [PAIR_W-1:0] pair_q;
   logic signed [PROD_W-1:0] pair_ext;
   logic signed [PROD_W-1:0] part [NB+1];

   always_ff @(posedge clk) begin
      if (rst)     pair_q <= '0;
      else if (en) pair_q <= PAIR_W'($signed(a)) + PAIR_W'($signed(b));
   end

   assign pair_ext = PROD_W'(pair_q);
   assign part[0]  = '0;

   for (genvar k = 0; k < NB; k++) begin : g_bit
      if (((MAG >> k) & 1) == 1) begin : g_add
         assign part[k+1] = part[k] + (pair_ext <<< k);
      end else begin : g_skip
         assign part[k+1] = part[k];
      end
   end

   always_ff @(posedge clk) begin
      if (rst)             prod <= '0;
      else if (en) begin
         if (COEF < 0)     prod <= -part[NB];
         else              prod <= part[NB];
      end
   end

endmodule

// File: rtl/hb_out_stage.sv
module hb_out_stage #(
   parameter int ACC_W = 26,
   parameter int W     = 12,
   parameter int FRAC  = 10,
   parameter int LAT   = 3
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    en,
   input  logic signed [ACC_W-1:0] acc,
   output logic                    out_valid,
   output logic [W-1:0]            out_data
);
   localparam int CNT_W = $clog2(LAT + 1);
   localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1 << (FRAC - 1));
   localparam logic signed [ACC_W-1:0] TOP  = ACC_W'((1 << (W - 1)) - 1);
   localparam logic signed [ACC_W-1:0] BOT  = -ACC_W'(1 << (W - 1));
   localparam logic [W-1:0] MID_CODE        = W'(1) << (W - 1);

   logic signed [ACC_W-1:0] rnd;
   logic signed [W-1:0]     clipped;
   logic [CNT_W-1:0]        fill;

   assign rnd = (acc + HALF) >>> FRAC;

   always_comb begin
      if (rnd > TOP)      clipped = {1'b0, {(W-1){1'b1}}};
      else if (rnd < BOT) clipped = {1'b1, {(W-1){1'b0}}};
      else                clipped = rnd[W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_data  <= MID_CODE;
         out_valid <= 1'b0;
         fill      <= '0;
      end else begin
         out_valid <= en && (fill == CNT_W'(LAT));
         if (en) begin
            out_data <= {~clipped[W-1], clipped[W-2:0]};
            if (fill != CNT_W'(LAT)) fill <= fill + 1'b1;
         end
      end
   end

   AST_CLIP_HIGH: assert property (@(posedge clk) disable iff (rst)
      (en && rnd > TOP) |=> (out_data == {W{1'b1}})) else $error("clip high"); // R7
   AST_CLIP_LOW: assert property (@(posedge clk) disable iff (rst)
      (en && rnd < BOT) |=> (out_data == '0)) else $error("clip low"); // R7

endmodule

// File: rtl/hb_lowpass.sv
module hb_lowpass #(
   parameter int DATA_W   = 12,
   parameter int NUM_TAPS = 11
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sample_en,
   input  logic [DATA_W-1:0] sample_in,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);
   import hb_lowpass_pkg::*;

   localparam int PAIRS  = (NUM_TAPS + 1) / 4;
   localparam int PAIR_W = DATA_W + 1;
   localparam int PROD_W = PAIR_W + COEF_FRAC;
   localparam int ACC_W  = PROD_W + $clog2(PAIRS + 1) + 1;
   localparam int LAT    = 3;
   localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);

   if (NUM_TAPS % 4 != 3) begin : g_bad_taps
      $error("hb_lowpass: tap count must be 4n-1");
   end
   if (PAIRS < 1 || PAIRS > MAX_PAIRS) begin : g_bad_pairs
      $error("hb_lowpass: no weight set for this tap count");
   end
   if (weight_total(PAIRS) != (1 << COEF_FRAC)) begin : g_bad_sum
      $error("hb_lowpass: weights do not give unity DC gain");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("hb_lowpass: data width too small");
   end

   logic signed [DATA_W-1:0]         in_s;
   logic [PAIRS-1:0][DATA_W-1:0]     near_tap;
   logic [PAIRS-1:0][DATA_W-1:0]     far_tap;
   logic signed [DATA_W-1:0]         centre_tap;
   logic signed [DATA_W-1:0]         ctr_q1;
   logic signed [DATA_W-1:0]         ctr_q2;
   logic signed [PROD_W-1:0]         prod [PAIRS];
   logic signed [ACC_W-1:0]          acc;

   // Offset binary to two's complement.
   assign in_s = {~sample_in[DATA_W-1], sample_in[DATA_W-2:0]};

   hb_tap_line #(.W(DATA_W), .TAPS(NUM_TAPS), .PAIRS(PAIRS)) u_line (
      .clk(clk), .rst(rst), .en(sample_en), .din(in_s),
      .near_tap(near_tap), .far_tap(far_tap), .centre_tap(centre_tap)
   );

   for (genvar j = 0; j < PAIRS; j++) begin : g_pair
      hb_pair_mult #(.W(DATA_W), .COEF(side_coef(PAIRS, j)), .PROD_W(PROD_W)) u_mult (
         .clk(clk), .rst(rst), .en(sample_en),
         .a(near_tap[j]), .b(far_tap[j]), .prod(prod[j])
      );
   end

   // Centre tap rides alongside the pre-add and product stages.
   always_ff @(posedge clk) begin
      if (rst) begin
         ctr_q1 <= '0;
         ctr_q2 <= '0;
      end else if (sample_en) begin
         ctr_q1 <= centre_tap;
         ctr_q2 <= ctr_q1;
      end
   end

   always_comb begin
      acc = ACC_W'(ctr_q2) <<< (COEF_FRAC - 1);
      for (int j = 0; j < PAIRS; j++) acc = acc + ACC_W'(prod[j]);
   end

   hb_out_stage #(.ACC_W(ACC_W), .W(DATA_W), .FRAC(COEF_FRAC), .LAT(LAT)) u_out (
      .clk(clk), .rst(rst), .en(sample_en), .acc(acc),
      .out_valid(out_valid), .out_data(out_data)
   );

   AST_RESET_STATE: assert property (@(posedge clk)
      rst |=> (!out_valid && out_data == MID_CODE)) else $error("reset state"); // R1
   AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(sample_en)) else $error("valid without strobe"); // R3
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      (!$past(sample_en) && !$past(rst)) |-> $stable(out_data)) else $error("idle change"); // R2

endmodule

// File: tb/test_hb_lowpass.sv
module test_hb_lowpass;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        sample_en = 1'b0;
   logic [11:0] sample_in = 12'd0;
   logic        out_valid;
   logic [11:0] out_data;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   int hist [1024];
   int obs  [1024];
   int nh = 0;
   localparam int H [11] = '{12, 0, -56, 0, 300, 512, 300, 0, -56, 0, 12};

   always #10 clk = ~clk;

   hb_lowpass i_hb_lowpass (
      .clk(clk), .rst(rst), .sample_en(sample_en), .sample_in(sample_in),
      .out_valid(out_valid), .out_data(out_data)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int model(input int n);
      int acc, s, r;
      acc = 0;
      for (int i = 0; i < 11; i++) begin
         s = (n - i >= 0) ? hist[n - i] : 2048;
         acc += H[i] * (s - 2048);
      end
      r = (acc + 512) >>> 10;
      if (r > 2047) r = 2047;
      if (r < -2048) r = -2048;
      return r + 2048;
   endfunction

   task automatic push(input int v, input string req);
      int k;
      @(negedge clk);
      sample_en = 1'b1;
      sample_in = v[11:0];
      hist[nh] = v;
      k = nh;
      nh++;
      @(negedge clk);
      sample_en = 1'b0;
      obs[k] = int'(out_data);
      if (k >= 3) begin
         chk(out_valid == 1'b1, {req, " R3 valid"}, int'(out_valid), 1);
         chk(int'(out_data) == model(k - 3), req, int'(out_data), model(k - 3));
      end else begin
         chk(out_valid == 1'b0, {req, " R3 not yet valid"}, int'(out_valid), 0);
      end
      @(negedge clk);
      chk(out_valid == 1'b0, {req, " R3 pulse width"}, int'(out_valid), 0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      nh = 0;
   endtask

   task automatic t_reset_state();
      chk(int'(out_data) == 2048, "R1 R8 reset midscale", int'(out_data), 2048);
      chk(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
   endtask

   task automatic t_impulse();
      do_reset();
      push(3000, "R4 impulse");
      for (int i = 0; i < 14; i++) push(2048, "R4 impulse tail");
      // centre of the impulse reaches the output on push index 8
      chk(obs[8] == 2048 + 476, "R4 centre weight", obs[8], 2048 + 476);
   endtask

   task automatic t_dc();
      do_reset();
      for (int i = 0; i < 16; i++) push(3500, "R5 dc");
      chk(obs[15] == 3500, "R5 unity dc", obs[15], 3500);
   endtask

   task automatic t_round();
      do_reset();
      push(2049, "R6 plus half");
      for (int i = 0; i < 9; i++) push(2048, "R6 plus half tail");
      chk(obs[8] == 2049, "R6 +0.5 rounds up", obs[8], 2049);
      do_reset();
      push(2047, "R6 minus half");
      for (int i = 0; i < 9; i++) push(2048, "R6 minus half tail");
      chk(obs[8] == 2048, "R6 -0.5 rounds to zero", obs[8], 2048);
   endtask

   task automatic t_clip();
      int top, bot;
      do_reset();
      for (int i = 0; i < 12; i++) push(0, "R7 low rail");
      for (int i = 0; i < 12; i++) push(4095, "R7 rising step");
      for (int i = 0; i < 12; i++) push(0, "R7 falling step");
      top = 0;
      bot = 4095;
      for (int i = 3; i < nh; i++) begin
         if (obs[i] > top) top = obs[i];
         if (obs[i] < bot) bot = obs[i];
      end
      chk(top == 4095, "R7 clipped high", top, 4095);
      chk(bot == 0, "R7 clipped low", bot, 0);
   endtask

   task automatic t_quarter_rate();
      int mx, mn;
      do_reset();
      for (int i = 0; i < 6; i++) begin
         push(3048, "R9 fs/4");
         push(2048, "R9 fs/4");
         push(1048, "R9 fs/4");
         push(2048, "R9 fs/4");
      end
      mx = 0;
      mn = 4095;
      for (int i = nh - 4; i < nh; i++) begin
         if (obs[i] > mx) mx = obs[i];
         if (obs[i] < mn) mn = obs[i];
      end
      chk(mx == 2548, "R9 half gain peak", mx, 2548);
      chk(mn == 1548, "R9 half gain trough", mn, 1548);
   endtask

   task automatic t_idle_ignored();
      int held;
      do_reset();
      for (int i = 0; i < 6; i++) push(1000 + 300 * i, "R2 ramp");
      held = int'(out_data);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         sample_in = 12'(4095 - 511 * i);
         @(negedge clk);
         chk(int'(out_data) == held, "R2 idle hold", int'(out_data), held);
         chk(out_valid == 1'b0, "R2 idle valid", int'(out_valid), 0);
      end
      for (int i = 0; i < 6; i++) push(2500, "R2 after idle");
   endtask

   task automatic t_reset_with_strobe();
      do_reset();
      for (int i = 0; i < 8; i++) push(3900, "R1 fill");
      @(negedge clk);
      rst = 1'b1;
      sample_en = 1'b1;
      sample_in = 12'd4095;
      @(negedge clk);
      rst = 1'b0;
      sample_en = 1'b0;
      nh = 0;
      chk(int'(out_data) == 2048, "R1 reset beats strobe data", int'(out_data), 2048);
      chk(out_valid == 1'b0, "R1 reset beats strobe valid", int'(out_valid), 0);
      for (int i = 0; i < 10; i++) push(2048, "R1 cleared line");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset_state();
      for (int i = 0; i < 3; i++) push(2048, "R3 priming");
      t_impulse();
      t_dc();
      t_round();
      t_clip();
      t_quarter_rate();
      t_idle_ignored();
      t_reset_with_strobe();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule